// File: doc/BRIEF.md
# Complement-Walk Pattern Generator

This block produces a stream of varied bit patterns to drive test outputs. A pattern register holds the current word. On every step the register takes the bitwise inverse of its own value and adds one only when the old top bit was set. Any carry out of the top bit is dropped. The sequence alternates between a value and its near-inverse, so it moves inward from both ends of the range instead of counting upward. Seeded with 0 it gives 0, all-ones, 1, all-ones minus 1, 2, and so on. The word with only the top bit set maps to itself.

Steps are paced from the master clock by an internal prescaler. A count runs from 1 to DIV. Each time it reaches DIV, a slow phase bit toggles. A step happens on the master edge where that phase falls from high to low, so there is one step every 2*DIV master cycles. No derived clock is used. A load strobe writes a seed word and restarts the prescaler. A synchronous reset clears the pattern to zero. The output is a valid-only stream. `step_vld_o` is high for one cycle with each new word. There is no back-pressure: the generator is paced by its own prescaler and cannot stall, so the consumer must take every word in the cycle it is flagged.

Top module: `cw_pattern_gen`

## Requirements
- R1: While `rst_i` is high, and in the cycle after it is released, `pattern_o` is 0 and `step_vld_o` is 0.
- R2: On a step, the new `pattern_o` equals the bitwise NOT of the old value plus the old bit W-1, taken modulo 2^W.
- R3: When the old value has bit W-1 clear, a step gives exactly its bitwise NOT, with no increment.
- R4: The value with only bit W-1 set stays unchanged across steps.
- R5: The first step comes on the 2*DIV-th master edge after reset release or after a load edge. Each later step follows the previous one by exactly 2*DIV edges.
- R6: `step_vld_o` is high for exactly one cycle per step. `pattern_o` changes only in cycles where `step_vld_o` is high, or after a load or reset.
- R7: A load writes `seed_i` into `pattern_o` on the next edge with `step_vld_o` low, and restarts the prescaler. A load wins over a step that falls on the same edge.
- R8: Reset wins over load: a load strobe during reset leaves `pattern_o` at 0.
- R9: With W=16 and DIV=16, the words seen after loading seed 125 are 125, 65410, 126, 65409, 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Seed-load strobe |
| seed_i | input | W | Seed word written on load |
| pattern_o | output | W | Current pattern word |
| step_vld_o | output | 1 | One-cycle pulse that flags each new stepped word |

## Verification
The checker assumes that `load_i` and `rst_i` are sampled only at master rising edges. Its step-spacing counter assumes that a load is the only event, apart from reset, that restarts the prescaler. It also assumes DIV is at least 1, so two step pulses can never be adjacent. The bench changes every input on the falling edge and never holds load high for more than one cycle, except during reset. Because the output has no ready, the stimulus applies no back-pressure. It only observes each flagged word.

// File: rtl/cw_pkg.sv
package cw_pkg;
  // Bits needed to hold prescaler counts 1..div.
  function automatic int cw_cnt_bits(input int div);
    return (div < 1) ? 1 : $clog2(div + 1);
  endfunction
endpackage

// File: rtl/cw_prescaler.sv
module cw_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic restart_i,
  output logic step_en_o
);
  localparam int CW = cw_pkg::cw_cnt_bits(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV);
  localparam logic [CW-1:0] FIRST = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) begin
      cnt_q   <= FIRST;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= FIRST;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + FIRST;
    end
  end

  // Phase is about to fall on this edge: one-cycle step enable.
  assign step_en_o = (cnt_q == LAST) && phase_q;
endmodule

// File: rtl/cw_next_value.sv
module cw_next_value #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] inc;

  always_comb begin
    inc   = '0;
    inc[0] = cur_i[W-1];
    // Sum kept to W bits: carry out is discarded.
    nxt_o = ~cur_i + inc;
  end
endmodule

// File: rtl/cw_pattern_reg.sv
module cw_pattern_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_en_i,
  input  logic [W-1:0] nxt_i,
  output logic [W-1:0] pattern_o,
  output logic         step_vld_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pattern_o  <= '0;
      step_vld_o <= 1'b0;
    end else if (load_i) begin
      pattern_o  <= seed_i;
      step_vld_o <= 1'b0;
    end else if (step_en_i) begin
      pattern_o  <= nxt_i;
      step_vld_o <= 1'b1;
    end else begin
      step_vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cw_pattern_gen.sv
module cw_pattern_gen #(
  parameter int W   = 16,
  parameter int DIV = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] pattern_o,
  output logic         step_vld_o
);
  logic         step_en;
  logic [W-1:0] nxt;

  cw_prescaler #(.DIV(DIV)) u_presc (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .restart_i (load_i),
    .step_en_o (step_en)
  );

  cw_next_value #(.W(W)) u_next (
    .cur_i (pattern_o),
    .nxt_o (nxt)
  );

  cw_pattern_reg #(.W(W)) u_reg (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (load_i),
    .seed_i     (seed_i),
    .step_en_i  (step_en),
    .nxt_i      (nxt),
    .pattern_o  (pattern_o),
    .step_vld_o (step_vld_o)
  );
endmodule

// File: rtl/cw_pattern_chk.sv
module cw_pattern_chk #(
  parameter int W   = 16,
  parameter int DIV = 16
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         load_i,
  input logic [W-1:0] seed_i,
  input logic [W-1:0] pattern_o,
  input logic         step_vld_o
);
  localparam int GW = $clog2(2 * DIV + 2) + 1;
  localparam logic [GW-1:0] PERIOD = GW'(2 * DIV);
  localparam logic [GW-1:0] ONE = GW'(1);

  // Edges since the last reset, load or observed step.
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk_i) begin
    if (rst_i || load_i) gap_q <= '0;
    else if (step_vld_o) gap_q <= ONE;
    else if (gap_q != {GW{1'b1}}) gap_q <= gap_q + ONE;
  end

  // R2
  step_rule_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    step_vld_o |-> pattern_o == (~$past(pattern_o) + {{(W-1){1'b0}}, $past(pattern_o[W-1])}));

  // R3
  low_half_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_vld_o && !$past(pattern_o[W-1])) |-> pattern_o == ~$past(pattern_o));

  // R5
  step_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    step_vld_o |-> gap_q == PERIOD);

  // R5
  no_missed_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    gap_q <= PERIOD);

  // R6
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    step_vld_o |=> !step_vld_o);

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!step_vld_o && !$past(load_i) && !$past(rst_i)) |-> $stable(pattern_o));

  // R7
  load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> (pattern_o == $past(seed_i)) && !step_vld_o);
endmodule

bind cw_pattern_gen cw_pattern_chk #(.W(W), .DIV(DIV)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .load_i     (load_i),
  .seed_i     (seed_i),
  .pattern_o  (pattern_o),
  .step_vld_o (step_vld_o)
);

// File: tb/test_cw_pattern_gen.sv
`timescale 1ns/1ps
module test_cw_pattern_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_b = 1'b0, load_s = 1'b0;
  logic [15:0] seed_b = '0, pat_b;
  logic [3:0]  seed_s = '0, pat_s;
  logic vld_b, vld_s;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  cw_pattern_gen #(.W(16), .DIV(16)) i_cw_pattern_gen (
    .clk_i(clk), .rst_i(rst), .load_i(load_b), .seed_i(seed_b),
    .pattern_o(pat_b), .step_vld_o(vld_b));

  cw_pattern_gen #(.W(4), .DIV(2)) i_cw_pattern_gen_small (
    .clk_i(clk), .rst_i(rst), .load_i(load_s), .seed_i(seed_s),
    .pattern_o(pat_s), .step_vld_o(vld_s));

  function automatic logic [15:0] ref16(input logic [15:0] v);
    return (v[15] ? 16'd1 : 16'd0) + ~v;
  endfunction

  function automatic logic [3:0] ref4(input logic [3:0] v);
    return (v[3] ? 4'd1 : 4'd0) + ~v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_big(output int n);
    logic [15:0] prev;
    bit seen;
    prev = pat_b; seen = 0; n = 0;
    while (!seen && n < 2000) begin
      @(posedge clk); @(negedge clk); n++;
      if (vld_b) seen = 1;
      else if (pat_b != prev) chk(0, "R6 hold", pat_b, prev);
    end
  endtask

  task automatic step_small(output int n);
    logic [3:0] prev;
    bit seen;
    prev = pat_s; seen = 0; n = 0;
    while (!seen && n < 200) begin
      @(posedge clk); @(negedge clk); n++;
      if (vld_s) seen = 1;
      else if (pat_s != prev) chk(0, "R6 hold", pat_s, prev);
    end
  endtask

  task automatic load_big(input logic [15:0] s);
    load_b = 1'b1; seed_b = s;
    @(posedge clk); @(negedge clk);
    load_b = 1'b0;
    chk(pat_b == s, "R7 load value", pat_b, s);
    chk(!vld_b, "R7 no pulse on load", vld_b, 0);
  endtask

  task automatic load_small(input logic [3:0] s);
    load_s = 1'b1; seed_s = s;
    @(posedge clk); @(negedge clk);
    load_s = 1'b0;
    chk(pat_s == s, "R7 load value", pat_s, s);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] exp16;
    logic [3:0] v, e4;
    // R8: load strobes during reset are ignored
    load_b = 1'b1; seed_b = 16'hABCD; load_s = 1'b1; seed_s = 4'h5;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(pat_b == 0, "R8 reset beats load", pat_b, 0);
    chk(pat_s == 0, "R8 reset beats load", pat_s, 0);
    chk(!vld_b, "R1 valid low in reset", vld_b, 0);
    rst = 1'b0; load_b = 1'b0; load_s = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(pat_b == 0 && !vld_b, "R1 state after release", pat_b, 0);
    // first step: 2*DIV edges after release (one already taken)
    step_big(n);
    chk(n + 1 == 32, "R5 first step", n + 1, 32);
    chk(pat_b == 16'hFFFF, "R2 from zero", pat_b, 16'hFFFF);
    @(posedge clk); @(negedge clk);
    chk(!vld_b, "R6 one-cycle pulse", vld_b, 0);
    step_big(n);
    chk(n == 31, "R5 spacing", n + 1, 32);
    chk(pat_b == 16'd1, "R2 all-ones wraps", pat_b, 1);
    step_big(n);
    chk(pat_b == 16'hFFFE, "R3 complement only", pat_b, 16'hFFFE);

    // R9: walk from 125
    load_big(16'd125);
    step_big(n);
    chk(n == 32, "R5 after load", n, 32);
    chk(pat_b == 16'd65410, "R9 step1", pat_b, 65410);
    step_big(n); chk(pat_b == 16'd126, "R9 step2", pat_b, 126);
    step_big(n); chk(pat_b == 16'd65409, "R9 step3", pat_b, 65409);
    step_big(n); chk(pat_b == 16'd127, "R9 step4", pat_b, 127);

    // R4: fixed point
    load_big(16'h8000);
    step_big(n); chk(pat_b == 16'h8000, "R4 fixed point", pat_b, 16'h8000);
    step_big(n); chk(pat_b == 16'h8000 && n == 32, "R4 fixed point again", pat_b, 16'h8000);

    // R7: load on the same edge as a due step
    repeat (31) @(posedge clk);
    @(negedge clk);
    load_big(16'h1234);
    step_big(n);
    chk(n == 32, "R7 prescaler restarted", n, 32);
    exp16 = ref16(16'h1234);
    chk(pat_b == exp16, "R2 after coincident load", pat_b, exp16);

    // Exhaustive sweep of the small configuration
    for (int s = 0; s < 16; s++) begin
      load_small(4'(s));
      v = 4'(s);
      for (int k = 0; k < 6; k++) begin
        step_small(n);
        chk(n == 4, "R5 small spacing", n, 4);
        e4 = ref4(v);
        if (v[3]) chk(pat_s == e4, "R2 small step", pat_s, e4);
        else      chk(pat_s == e4, "R3 small step", pat_s, e4);
        v = e4;
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule